// File: doc/BRIEF.md
# Nonvolatile Program Memory Erase/Program Sequencer

This block controls a small on-chip program memory held in a register array of 24-bit words. Software configures an operation through a command register, loads a target address into a page register and an in-page offset register, and fills a 64-word row staging buffer through a separate word-write port. The memory is organised as erase pages of 8 rows, each row holding 64 words, so one page spans 512 words.

An operation is launched by setting the launch bit of the command register. The launch takes effect only when the two register writes just before it were the key values 0x55 and then 0xAA to the key register. An accepted launch raises a busy/stall output for a fixed, parameter-set number of cycles. At the end of that window the block either sets every word of the addressed page to all ones or copies the staging buffer into the addressed row. It then clears the launch bit by itself and forgets the unlock. A launch that is refused changes nothing and sets a sticky error flag.

The array can be read back at any time through a combinational read port.

Top module: `nvm_seq`

## Requirements
- R1: After reset, or while reset is asserted, `busy` is 0, `err` is 0 and `ctrl_rd` is 0x0000. Asserting reset during an operation drops `busy` at once.
- R2: The register select codes are 0 for command, 1 for key, 2 for page and 3 for offset. The command register holds the operation code in bits [3:0], write-enable in bit 6, the erase flag in bit 14 and the launch bit in bit 15. `ctrl_rd` returns those bits and reads 0 in all other positions.
- R3: A command write with bit 15 set is accepted only if the two register writes just before it were key 0x0055 and then key 0x00AA.
- R4: A key value other than the one expected next breaks the unlock, as does any page or offset write between the keys and the command write. A following launch is then refused.
- R5: A refused launch leaves `busy` at 0, leaves the array unchanged and sets `err`. `err` stays set until a command write with bit 15 clear, or until reset.
- R6: A launch is also refused when write-enable is 0, when the command is neither operation code 0010 with the erase flag set (page erase) nor operation code 0001 with the erase flag clear (row program), or when the word address {page[15:0], offset[15:0]} is 1024 or more (default size).
- R7: `busy` rises in the cycle after an accepted command write. It stays high for exactly ERASE_CYC cycles for an erase and PROG_CYC cycles for a program. `ctrl_rd[15]` reads 1 exactly while `busy` is high.
- R8: When an operation completes, bit 15 clears and the unlock state is cleared, so a launch with no new key pair is refused.
- R9: A page erase sets all 512 words of the page that holds the target address to 0xFFFFFF and leaves every other page unchanged.
- R10: A row program writes staging word i to the word at row base + i, for i from 0 to 63, in the row that holds the target address. It leaves all other words unchanged.
- R11: A write with `lat_we` stores `lat_wdata` at index `lat_idx` of the staging buffer. While `busy` is high, staging and register writes are ignored.
- R12: `rd_data` shows the array word at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 key, 2 page, 3 offset |
| reg_wdata | input | 16 | Register write data |
| lat_we | input | 1 | Staging buffer write strobe |
| lat_idx | input | 6 | Staging buffer word index |
| lat_wdata | input | 24 | Staging buffer write data |
| rd_addr | input | 10 | Array read address |
| rd_data | output | 24 | Array read data |
| ctrl_rd | output | 16 | Command register read-back |
| busy | output | 1 | Operation in progress; processor stall |
| err | output | 1 | Sticky refused-launch flag |

## Verification
The hardest situation to produce is one where a write the block should ignore lands in the middle of a busy window. Such a write must leave no trace, so the test has to reveal state that is otherwise hidden. To do this, the bench changes a staging word and the offset while a program is running. It then launches a second program with no reload and reads back both the original row and the row the corrupted offset would have hit. The unlock rules are covered by a table of key and command pairs that includes swapped keys, a bad first key, a repeated first key and an offset write placed between the keys and the launch. Each entry ends in either a timed operation or a raised error flag.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_KEY  = 2'd1,
    SEL_PAGE = 2'd2,
    SEL_OFS  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  localparam logic [3:0]  OP_PAGE_ERASE = 4'b0010;
  localparam logic [3:0]  OP_ROW_PROG   = 4'b0001;
  localparam int          B_LAUNCH      = 15;
  localparam int          B_ERASE       = 14;
  localparam int          B_WREN        = 6;
  localparam logic [15:0] KEY_A         = 16'h0055;
  localparam logic [15:0] KEY_B         = 16'h00AA;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [15:0] key_val,
  input  logic        other_we,
  input  logic        clr,
  output logic        armed
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr || other_we) begin
      st_d = UL_IDLE;
    end else if (key_we) begin
      case (st_q)
        UL_HALF: st_d = (key_val == KEY_B) ? UL_ARMED : UL_IDLE;
        default: st_d = (key_val == KEY_A) ? UL_HALF  : UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvm_timer.sv
module nvm_timer #(
  parameter int ERASE_CYC = 48,
  parameter int PROG_CYC  = 24,
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_erase,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign done = busy_q && (cnt_q == CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = is_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q - CW'(1);
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int NUM_PAGES     = 2,
  parameter int ROWS_PER_PAGE = 8,
  parameter int ROW_WORDS     = 64,
  parameter int WORD_W        = 24,
  localparam int PAGE_WORDS = ROWS_PER_PAGE * ROW_WORDS,
  localparam int DEPTH      = NUM_PAGES * PAGE_WORDS,
  localparam int AW         = $clog2(DEPTH),
  localparam int IW         = $clog2(ROW_WORDS),
  localparam int PAGE_SH    = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              lat_we,
  input  logic [IW-1:0]     lat_idx,
  input  logic [WORD_W-1:0] lat_wdata,
  input  logic              do_erase,
  input  logic              do_prog,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] lat_q [ROW_WORDS];
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (lat_we) lat_q[lat_idx] <= lat_wdata;
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (do_erase && ((AW'(w) >> PAGE_SH) == (tgt_addr >> PAGE_SH)))
        mem_q[w] <= '1;
      else if (do_prog && ((AW'(w) >> IW) == (tgt_addr >> IW)))
        mem_q[w] <= lat_q[w % ROW_WORDS];
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int NUM_PAGES     = 2,
  parameter int ROWS_PER_PAGE = 8,
  parameter int ROW_WORDS     = 64,
  parameter int WORD_W        = 24,
  parameter int ERASE_CYC     = 48,
  parameter int PROG_CYC      = 24,
  localparam int DEPTH = NUM_PAGES * ROWS_PER_PAGE * ROW_WORDS,
  localparam int AW    = $clog2(DEPTH),
  localparam int IW    = $clog2(ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  input  logic              lat_we,
  input  logic [IW-1:0]     lat_idx,
  input  logic [WORD_W-1:0] lat_wdata,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [15:0]       ctrl_rd,
  output logic              busy,
  output logic              err
);
  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  logic [3:0]  op_q, op_d;
  logic        wren_q, wren_d, erf_q, erf_d, launch_q, launch_d, err_q, err_d;
  logic [15:0] page_q, page_d, ofs_q, ofs_d;
  logic        wr_ok, cmd_we, key_we, other_we, launch_req, cmd_ok, in_range, accept;
  logic        armed, done, busy_w;
  logic [31:0] full_addr;

  assign wr_ok      = reg_we && !busy_w;
  assign cmd_we     = wr_ok && (reg_sel == SEL_CMD);
  assign key_we     = wr_ok && (reg_sel == SEL_KEY);
  assign other_we   = wr_ok && (reg_sel != SEL_KEY);
  assign launch_req = cmd_we && reg_wdata[B_LAUNCH];
  assign full_addr  = {page_q, ofs_q};
  assign in_range   = full_addr < 32'(DEPTH);
  assign cmd_ok     = ((reg_wdata[3:0] == OP_PAGE_ERASE) &&  reg_wdata[B_ERASE]) ||
                      ((reg_wdata[3:0] == OP_ROW_PROG)   && !reg_wdata[B_ERASE]);
  assign accept     = launch_req && armed && reg_wdata[B_WREN] && cmd_ok && in_range;

  // next-state
  always_comb begin
    op_d     = op_q;
    wren_d   = wren_q;
    erf_d    = erf_q;
    launch_d = launch_q;
    err_d    = err_q;
    page_d   = page_q;
    ofs_d    = ofs_q;
    if (cmd_we) begin
      op_d     = reg_wdata[3:0];
      wren_d   = reg_wdata[B_WREN];
      erf_d    = reg_wdata[B_ERASE];
      launch_d = accept;
      if (!reg_wdata[B_LAUNCH]) err_d = 1'b0;
      else if (!accept)         err_d = 1'b1;
    end else if (done) begin
      launch_d = 1'b0;
    end
    if (wr_ok && (reg_sel == SEL_PAGE)) page_d = reg_wdata;
    if (wr_ok && (reg_sel == SEL_OFS))  ofs_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      op_q     <= '0;
      wren_q   <= 1'b0;
      erf_q    <= 1'b0;
      launch_q <= 1'b0;
      err_q    <= 1'b0;
      page_q   <= '0;
      ofs_q    <= '0;
    end else begin
      op_q     <= op_d;
      wren_q   <= wren_d;
      erf_q    <= erf_d;
      launch_q <= launch_d;
      err_q    <= err_d;
      page_q   <= page_d;
      ofs_q    <= ofs_d;
    end
  end

  nvm_unlock u_unlock (
    .clk      (clk),
    .rst_n    (srst_n),
    .key_we   (key_we),
    .key_val  (reg_wdata),
    .other_we (other_we),
    .clr      (done),
    .armed    (armed)
  );

  nvm_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (accept),
    .is_erase (reg_wdata[3:0] == OP_PAGE_ERASE),
    .busy     (busy_w),
    .done     (done)
  );

  nvm_array #(
    .NUM_PAGES     (NUM_PAGES),
    .ROWS_PER_PAGE (ROWS_PER_PAGE),
    .ROW_WORDS     (ROW_WORDS),
    .WORD_W        (WORD_W)
  ) u_array (
    .clk       (clk),
    .lat_we    (lat_we && !busy_w),
    .lat_idx   (lat_idx),
    .lat_wdata (lat_wdata),
    .do_erase  (done && (op_q == OP_PAGE_ERASE)),
    .do_prog   (done && (op_q == OP_ROW_PROG)),
    .tgt_addr  (full_addr[AW-1:0]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  assign ctrl_rd = {launch_q, erf_q, 7'b0, wren_q, 2'b0, op_q};
  assign busy    = busy_w;
  assign err     = err_q;
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk #(
  parameter int ERASE_CYC = 48,
  parameter int PROG_CYC  = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [15:0] reg_wdata,
  input logic [15:0] ctrl_rd,
  input logic        busy,
  input logic        err
);
  logic [15:0] bcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt_q <= '0;
    else if (busy) bcnt_q <= bcnt_q + 16'd1;
    else           bcnt_q <= '0;
  end

  // R7: the launch bit and the stall output agree
  a_r7_launch_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy == ctrl_rd[15]);

  // R7: the busy window lasts the configured number of cycles
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (32'(bcnt_q) ==
      (($past(ctrl_rd[3:0]) == 4'b0010) ? ERASE_CYC : PROG_CYC)));

  // R3: busy rises only after a command write carrying the launch bit
  a_r3_busy_after_launch_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && (reg_sel == 2'd0) && reg_wdata[15]));

  // R5: the error flag rises only on a refused launch
  a_r5_err_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(reg_we && (reg_sel == 2'd0) && reg_wdata[15]) && !busy));

  // R8: completion leaves the launch bit clear
  a_r8_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ctrl_rd[15]);
endmodule

bind nvm_seq nvm_seq_chk #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .ctrl_rd   (ctrl_rd),
  .busy      (busy),
  .err       (err)
);

// File: tb/nvm_seq_test.sv
`timescale 1ns/1ps
module nvm_seq_test;
  localparam int ECYC = 48;
  localparam int PCYC = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        lat_we = 1'b0;
  logic [5:0]  lat_idx = '0;
  logic [23:0] lat_wdata = '0;
  logic [9:0]  rd_addr = '0;
  logic [23:0] rd_data;
  logic [15:0] ctrl_rd;
  logic        busy, err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvm_seq #(.ERASE_CYC(ECYC), .PROG_CYC(PCYC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .lat_we(lat_we), .lat_idx(lat_idx),
    .lat_wdata(lat_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_rd(ctrl_rd), .busy(busy), .err(err)
  );

  // key1, key2, command, offset write between keys and launch, accepted
  localparam logic [33:0] VEC [9] = '{
    {8'h55, 8'hAA, 16'h8041, 1'b0, 1'b1},
    {8'hAA, 8'h55, 16'h8041, 1'b0, 1'b0},
    {8'h55, 8'hAA, 16'h8041, 1'b1, 1'b0},
    {8'h55, 8'h55, 16'h8041, 1'b0, 1'b0},
    {8'h55, 8'hAA, 16'h8001, 1'b0, 1'b0},
    {8'h55, 8'hAA, 16'h8043, 1'b0, 1'b0},
    {8'h55, 8'hAA, 16'hC041, 1'b0, 1'b0},
    {8'h55, 8'hAA, 16'h8042, 1'b0, 1'b0},
    {8'h56, 8'hAA, 16'h8041, 1'b0, 1'b0}
  };

  function automatic logic [23:0] pat_a(int i);
    return 24'hA50000 + 24'(i) * 24'h000103;
  endfunction
  function automatic logic [23:0] pat_b(int i);
    return 24'h3C0F00 ^ (24'(i) << 4) ^ 24'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic lat(input int idx, input logic [23:0] d);
    @(negedge clk);
    lat_we = 1'b1; lat_idx = 6'(idx); lat_wdata = d;
    @(negedge clk);
    lat_we = 1'b0;
  endtask

  task automatic launch(input logic [15:0] cmd);
    wr(2'd1, 16'h0055);
    wr(2'd1, 16'h00AA);
    wr(2'd0, cmd);
  endtask

  // called at the negedge after the launch edge
  task automatic wait_busy(input string tag, input int exp_n);
    int n = 0;
    int bad = 0;
    while (busy && n < 1000) begin
      if (ctrl_rd[15] !== 1'b1) bad++;
      n++;
      @(negedge clk);
    end
    chk({tag, " busy length"}, 32'(n), 32'(exp_n));
    chk({tag, " launch bit high while busy"}, 32'(bad), 32'd0);
    chk({tag, " launch bit cleared"}, 32'(ctrl_rd[15]), 32'd0);
  endtask

  // kind 0: all ones, 1: pattern A, 2: pattern B
  task automatic chk_region(input string tag, input int base, input int n, input int kind);
    int bad = 0;
    logic [23:0] first_act = '0, first_exp = '0;
    for (int i = 0; i < n; i++) begin
      logic [23:0] e;
      e = (kind == 0) ? 24'hFFFFFF : (kind == 1) ? pat_a(i) : pat_b(i);
      rd_addr = 10'(base + i);
      #1;
      if (rd_data !== e) begin
        if (bad == 0) begin first_act = rd_data; first_exp = e; end
        bad++;
      end
    end
    chk(tag, {8'h0, first_act}, {8'h0, first_exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 err after reset", 32'(err), 32'd0);
    chk("R1 ctrl after reset", 32'(ctrl_rd), 32'd0);

    // R2 field read-back, other bits read zero
    wr(2'd0, 16'h7FFF);
    chk("R2 ctrl fields", 32'(ctrl_rd), 32'h404F);
    wr(2'd0, 16'h0000);

    // R9 erase page 1 via offset 0x200
    wr(2'd3, 16'h0200);
    launch(16'hC042);
    chk("R7 busy after erase launch", 32'(busy), 32'd1);
    wait_busy("R7 erase", ECYC);
    chk_region("R9 page1 erased", 512, 512, 0);

    // R10 program row 0 of page 1 with pattern A
    for (int i = 0; i < 64; i++) lat(i, pat_a(i));
    launch(16'h8041);
    wait_busy("R7 program", PCYC);
    chk_region("R10 page1 row0 programmed", 512, 64, 1);
    chk_region("R10 page1 row1 untouched", 576, 64, 0);

    // R9 erase page 0 at an unaligned offset; page 1 untouched
    wr(2'd3, 16'h0003);
    launch(16'hC042);
    wait_busy("R9 erase page0", ECYC);
    chk_region("R9 page0 erased", 0, 512, 0);
    chk_region("R9 page1 row0 kept", 512, 64, 1);

    // R10/R12 program row 2 with pattern B
    for (int i = 0; i < 64; i++) lat(i, pat_b(i));
    wr(2'd3, 16'h0080);
    launch(16'h8041);
    wait_busy("R10 program row2", PCYC);
    chk_region("R10 row2 programmed", 128, 64, 2);
    chk_region("R10 row1 kept", 64, 64, 0);
    chk_region("R10 row3 kept", 192, 64, 0);
    rd_addr = 10'd130; #1;
    chk("R12 read word 130", {8'h0, rd_data}, {8'h0, pat_b(2)});

    // R8 completion clears the unlock
    wr(2'd0, 16'h8041);
    chk("R8 launch without new keys refused", 32'(busy), 32'd0);
    chk("R8 err set", 32'(err), 32'd1);
    wr(2'd0, 16'h0000);
    chk("R5 err cleared", 32'(err), 32'd0);

    // R3/R4/R5/R6 unlock and command table
    wr(2'd3, 16'h0040);
    for (int v = 0; v < 9; v++) begin
      wr(2'd1, {8'h00, VEC[v][33:26]});
      wr(2'd1, {8'h00, VEC[v][25:18]});
      if (VEC[v][1]) wr(2'd3, 16'h0040);
      wr(2'd0, VEC[v][17:2]);
      chk($sformatf("R3 R4 R6 vector %0d busy", v), 32'(busy), 32'(VEC[v][0]));
      if (VEC[v][0]) begin
        wait_busy($sformatf("R3 vector %0d", v), PCYC);
        chk($sformatf("R3 vector %0d err", v), 32'(err), 32'd0);
      end else begin
        chk($sformatf("R5 vector %0d err", v), 32'(err), 32'd1);
        wr(2'd0, 16'h0000);
        chk($sformatf("R5 vector %0d err clear", v), 32'(err), 32'd0);
      end
    end
    chk_region("R5 row2 unchanged after refusals", 128, 64, 2);

    // R6 address out of range
    wr(2'd2, 16'h0001);
    launch(16'h8041);
    chk("R6 page out of range refused", 32'(busy), 32'd0);
    chk("R6 page out of range err", 32'(err), 32'd1);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0400);
    launch(16'hC042);
    chk("R6 offset out of range refused", 32'(busy), 32'd0);
    wr(2'd0, 16'h0000);

    // R11 writes during busy are ignored
    wr(2'd3, 16'h00C0);
    launch(16'h8041);
    lat(0, 24'h123456);
    wr(2'd3, 16'h0300);
    while (busy) @(negedge clk);
    chk_region("R11 row3 programmed", 192, 64, 2);
    launch(16'h8041);
    chk("R11 offset kept, relaunch accepted", 32'(busy), 32'd1);
    while (busy) @(negedge clk);
    rd_addr = 10'd192; #1;
    chk("R11 staging word kept", {8'h0, rd_data}, {8'h0, pat_b(0)});
    chk_region("R11 offset write ignored", 768, 64, 0);

    // R1 reset during an operation
    launch(16'hC042);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 busy drops in reset", 32'(busy), 32'd0);
    chk("R1 ctrl cleared in reset", 32'(ctrl_rd), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after second reset", 32'(busy), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule